// File: doc/BRIEF.md
# Serial-Load Latched Display Driver

This block drives the 20 segment or grid lines of a high-voltage display from a three-wire serial link. A host sends a bit stream on a data line with a shift clock. An enable level frames each transfer. Shift clock pulses count only while enable is high. Each rising shift clock edge moves one bit into an internal shift register. When enable drops, the register contents are copied into an output latch, and the latch drives the display lines. A blank input turns every line off at once, and the latched pattern is kept. A serial output carries the last register stage, so several drivers can be chained.

The four external serial pins are asynchronous to the fast system clock. Each one passes through a two-flop synchronizer. The block then detects the edges of the shift clock and of enable in the system clock domain. The system clock must run at least eight times faster than the fastest shift clock. A small controller sets when the register shifts and when the latch loads. It has three states:

- `ST_IDLE` (enable low). It moves to `ST_SHIFT` when the synchronized enable is high.
- `ST_SHIFT` (transfer open). It moves to `ST_LOAD` on a falling edge of enable.
- `ST_LOAD`, which lasts one cycle and copies the register into the latch. It then returns to `ST_SHIFT` if enable is already high again, and to `ST_IDLE` if it is not.

Top module: `ser_disp_drv`

## Requirements
- R1: A synchronous reset clears the shift register and the output latch to zero, and drives `seg_o` and `ser_dout_o` low.
- R2: Shift clock edges that arrive while enable is low do not change the shift register or `ser_dout_o`. A later load with no clock pulses shows the pattern that was shifted in before those edges.
- R3: Each rising shift clock edge with enable high shifts in one bit. After 20 bits, the k-th bit sent (counting from 0) drives `seg_o[k]`, so the first bit sent drives `seg_o[0]`.
- R4: A falling edge of enable copies the full register into the output latch, and `seg_o` then shows the new pattern.
- R5: While bits are being shifted, `seg_o` keeps showing the pattern latched before.
- R6: A latched 1 turns its output on (`seg_o` bit = 1), and a latched 0 turns it off. This holds for all-ones, all-zeros and mixed patterns.
- R7: While `blank_i` is 1, every bit of `seg_o` is 0. When blank is released, the latched pattern reappears unchanged.
- R8: Blank does not interact with enable. A transfer made while blank is high still updates the latch, and the new pattern appears when blank is released.
- R9: `ser_dout_o` carries the last register stage (the bit that will drive `seg_o[0]`). It updates only after a falling shift clock edge and does not change on a rising one. After n shifts of a new word following a previously loaded word P, it equals P[n] for n < 20, and the word's first bit for n = 20.
- R10: Shifting in 20 zeros with enable high and then dropping enable turns every output off, whatever was shown before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the shift clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Asynchronous serial shift clock |
| ser_din_i | input | 1 | Asynchronous serial data |
| load_en_i | input | 1 | Transfer envelope; its falling edge loads the latch |
| blank_i | input | 1 | Forces all outputs off while high |
| seg_o | output | NUM_OUT | Display line drive; 1 means on |
| ser_dout_o | output | 1 | Last shift stage, for chaining |
| | | | |

## Verification
If the shift register holds a wrong bit, `ser_dout_o` shows it at most 20 shift clocks later, because every stage passes through the output. If the register takes a bit in the wrong order or at the wrong time, the error appears on `seg_o` at the next enable fall, about four system cycles after the pin changes. A controller that reaches `ST_LOAD` at the wrong moment shows up in the middle of a transfer, when `seg_o` should still hold the old pattern. A blank path that corrupts the latch shows up as soon as blank is released.

// File: rtl/disp_pkg.sv
package disp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2
    } ld_state_t;
endpackage

// File: rtl/disp_sync.sv
module disp_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/disp_ctrl.sv
module disp_ctrl
    import disp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_s,
    input  logic      en_fall,
    input  logic      sclk_rise,
    input  logic      sclk_fall,
    output logic      shift_o,
    output logic      load_o,
    output logic      dout_upd_o,
    output ld_state_t state_o
);
    ld_state_t state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (en_s)    state_n = ST_SHIFT;
            ST_SHIFT: if (en_fall) state_n = ST_LOAD;
            ST_LOAD:  state_n = en_s ? ST_SHIFT : ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    always_comb begin
        shift_o    = (state_q == ST_SHIFT) && en_s && sclk_rise;
        dout_upd_o = (state_q == ST_SHIFT) && en_s && sclk_fall;
        load_o     = (state_q == ST_LOAD);
    end

    assign state_o = state_q;
endmodule

// File: rtl/disp_path.sv
module disp_path #(
    parameter int N = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_i,
    input  logic         load_i,
    input  logic         dout_upd_i,
    input  logic         din_i,
    output logic [N-1:0] sr_o,
    output logic [N-1:0] lat_o,
    output logic         dout_o
);
    logic [N-1:0] sr_q, lat_q;
    logic         dout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            lat_q  <= '0;
            dout_q <= 1'b0;
        end else begin
            if (shift_i)    sr_q   <= {din_i, sr_q[N-1:1]};
            if (load_i)     lat_q  <= sr_q;
            if (dout_upd_i) dout_q <= sr_q[0];
        end
    end

    assign sr_o   = sr_q;
    assign lat_o  = lat_q;
    assign dout_o = dout_q;
endmodule

// File: rtl/ser_disp_drv.sv
module ser_disp_drv
    import disp_pkg::*;
#(
    parameter int NUM_OUT     = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_clk_i,
    input  logic               ser_din_i,
    input  logic               load_en_i,
    input  logic               blank_i,
    output logic [NUM_OUT-1:0] seg_o,
    output logic               ser_dout_o
);
    localparam int NIN = 4;

    logic [NIN-1:0] raw_w, syn_w;
    logic           sclk_s, din_s, en_s, blank_s;
    logic           sclk_d, en_d;
    logic           sclk_rise, sclk_fall, en_fall;
    logic           shift_w, load_w, dout_upd_w;
    ld_state_t      st_w;
    logic [NUM_OUT-1:0] sr_w, lat_w;

    assign raw_w = {blank_i, load_en_i, ser_din_i, ser_clk_i};

    disp_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_w),
        .q_o (syn_w)
    );

    assign sclk_s  = syn_w[0];
    assign din_s   = syn_w[1];
    assign en_s    = syn_w[2];
    assign blank_s = syn_w[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            en_d   <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            en_d   <= en_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign en_fall   = ~en_s & en_d;

    disp_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .en_s       (en_s),
        .en_fall    (en_fall),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .shift_o    (shift_w),
        .load_o     (load_w),
        .dout_upd_o (dout_upd_w),
        .state_o    (st_w)
    );

    disp_path #(.N(NUM_OUT)) u_path (
        .clk        (clk),
        .rst        (rst),
        .shift_i    (shift_w),
        .load_i     (load_w),
        .dout_upd_i (dout_upd_w),
        .din_i      (din_s),
        .sr_o       (sr_w),
        .lat_o      (lat_w),
        .dout_o     (ser_dout_o)
    );

    assign seg_o = blank_s ? '0 : lat_w;
endmodule

// File: rtl/disp_chk.sv
module disp_chk
    import disp_pkg::*;
#(
    parameter int N = 20
) (
    input logic         clk,
    input logic         rst,
    input ld_state_t    st,
    input logic [N-1:0] sr,
    input logic [N-1:0] latch,
    input logic [N-1:0] seg,
    input logic         sclk_fall,
    input logic         dout
);
    AST_SR_FROZEN_OUTSIDE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (st != ST_SHIFT) |=> $stable(sr));  // R2
    AST_LATCH_COPIES_REG: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOAD) |=> (latch == $past(sr)));  // R4
    AST_LATCH_HELD_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
        (st != ST_LOAD) |=> $stable(latch));  // R5
    AST_OUT_WITHIN_LATCH: assert property (@(posedge clk) disable iff (rst)
        ((seg & ~latch) == '0));  // R7
    AST_DOUT_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
        !sclk_fall |=> $stable(dout));  // R9
endmodule

bind ser_disp_drv disp_chk #(.N(NUM_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .st        (st_w),
    .sr        (sr_w),
    .latch     (lat_w),
    .seg       (seg_o),
    .sclk_fall (sclk_fall),
    .dout      (ser_dout_o)
);

// File: tb/tb_ser_disp_drv.sv
module tb_ser_disp_drv;
    localparam int N = 20;
    localparam logic [N-1:0] MASK = {N{1'b1}};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk = 1'b0, din = 1'b0, en = 1'b0, blank = 1'b0;
    logic [N-1:0] seg;
    logic         dout;

    int n_chk  = 0;
    int n_fail = 0;
    logic [N-1:0] reg_model = '0;
    logic [N-1:0] lat_model = '0;

    always #5 clk = ~clk;

    ser_disp_drv dut (
        .clk        (clk),
        .rst        (rst),
        .ser_clk_i  (sclk),
        .ser_din_i  (din),
        .load_en_i  (en),
        .blank_i    (blank),
        .seg_o      (seg),
        .ser_dout_o (dout)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_bit(input logic b);
        din = b;
        cyc(2);
        sclk = 1'b1;
        cyc(4);
        sclk = 1'b0;
        cyc(4);
    endtask

    // Shifts a word in (bit k first-in drives seg[k]) and loads it.
    task automatic load_word(input logic [N-1:0] w);
        en = 1'b1;
        cyc(4);
        for (int k = 0; k < N; k++) begin
            din = w[k];
            cyc(2);
            sclk = 1'b1;
            cyc(4);
            // R9: no dout change on the rising edge; value after k shifts
            chk(dout == reg_model[k], "R9 rise", dout, reg_model[k]);
            sclk = 1'b0;
            cyc(4);
            // R9: after k+1 shifts dout = prev[k+1] or first new bit
            if (k + 1 < N) chk(dout == reg_model[k+1], "R9 fall", dout, reg_model[k+1]);
            else           chk(dout == w[0], "R9 fall", dout, w[0]);
            if (k == N / 2)
                chk(seg == (blank ? '0 : lat_model), "R5 old pattern held", seg, lat_model);
        end
        en = 1'b0;
        cyc(6);
        reg_model = w;
        lat_model = w;
        chk(seg == (blank ? '0 : w), "R4 R3 R6 loaded", seg, w);
    endtask

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(1);
        chk(seg == '0, "R1 seg", seg, 0);
        chk(dout == 1'b0, "R1 dout", dout, 0);

        // R3: walking one, bit k lands on seg[k]
        for (int k = 0; k < N; k++) load_word(N'(1) << k);
        // R6: all ones, all zeros, alternating
        load_word(MASK);
        load_word('0);
        load_word(N'(20'hAAAAA));
        load_word(N'(20'h55555));
        for (int i = 1; i <= 6; i++) load_word(N'((i * 32'h2F1B5 + 7) & MASK));

        // R2: clocks while enable is low are ignored
        load_word(N'(20'h3C5A1));
        for (int i = 0; i < 5; i++) pulse_bit(1'b1);
        chk(dout == reg_model[0], "R2 dout", dout, reg_model[0]);
        en = 1'b1;
        cyc(6);
        en = 1'b0;
        cyc(6);
        chk(seg == N'(20'h3C5A1), "R2 reload without clocks", seg, 20'h3C5A1);

        // R7: blank forces off, latch preserved
        blank = 1'b1;
        cyc(4);
        chk(seg == '0, "R7 blanked", seg, 0);
        blank = 1'b0;
        cyc(4);
        chk(seg == N'(20'h3C5A1), "R7 restored", seg, 20'h3C5A1);

        // R8: transfer under blank still updates latch
        blank = 1'b1;
        cyc(4);
        load_word(N'(20'h0F0F3));
        chk(seg == '0, "R8 blank during load", seg, 0);
        blank = 1'b0;
        cyc(4);
        chk(seg == N'(20'h0F0F3), "R8 new pattern after unblank", seg, 20'h0F0F3);

        // R10: clear sequence
        load_word(MASK);
        load_word('0);
        chk(seg == '0, "R10 cleared", seg, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule